// File: doc/BRIEF.md
# Iterative AES-128 Round Engine

This block encrypts or decrypts one 128-bit block with AES-128 in electronic-codebook fashion. It works through one 32-bit state column per clock, so each block takes a fixed 44 enabled cycles. That is eleven round-key additions of four columns each. Four byte substitution lanes and one column mixer are shared across the columns. The round keys come from an external key store. The engine publishes the index of the round key it needs in the current cycle, and it expects the matching 128-bit key on `round_key` in that same cycle.

A block starts on the first enabled clock edge. At that edge the engine captures `din` and the direction select. Holding `en` high makes the engine stream: the edge that ends the valid cycle of one block is the first edge of the next block. Dropping `en` freezes the engine wherever it is. A synchronous `clr` discards the block in flight and leaves the key store alone. The parameter `MODE` fixes the direction: 1 gives encrypt only, 2 gives decrypt only, and 3 lets `enc_sel` choose.

Top module: `aes128_iter_core`

## Requirements
- R1: With `enc_sel`=1 at the start edge, the result is the AES-128 encryption of the captured block under the supplied round keys.
- R2: With `enc_sel`=0 at the start edge, the result is the AES-128 decryption of the captured block. This is the inverse cipher, and it uses the round keys from index 10 down to 0.
- R3: With `en` and `key_ready` held high, `dout_valid` is high in the cycle after the 44th processing edge of a block. It is high for one cycle only, and `dout` carries the result in that cycle.
- R4: With `en` held high, the edge that closes a valid cycle samples `din` as the next block, so successive results come exactly 44 cycles apart.
- R5: An edge with `en` low changes no processing state. Each such edge delays the result by one cycle, and the result is unchanged.
- R6: An edge with `clr` high aborts the block in flight, and no result of that block appears. The next enabled edge starts a fresh block from `din`.
- R7: No processing step is taken on an edge where `key_ready` is low.
- R8: `din` is sampled only on the first edge of a block, so later changes to `din` do not alter that block's result.
- R9: `rk_idx` is a round number from 0 to 10. During rounds 0 to 10 it counts up for encryption (0,1,…,10) and down for decryption (10,9,…,0), and it holds for four cycles per round.
- R10: After reset, `dout_valid` is 0 and the engine waits at its first step. In that state `rk_idx` shows 0 if `enc_sel` is 1 and 10 if `enc_sel` is 0.
- R11: The direction is taken from `enc_sel` at the first edge of a block, and later changes of `enc_sel` within that block have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance enable; low pauses the engine |
| clr | input | 1 | Synchronous abort of the block in flight |
| enc_sel | input | 1 | 1 to encrypt, 0 to decrypt (used when MODE is 3) |
| key_ready | input | 1 | Round keys are available; low blocks progress |
| din | input | 128 | Input block, byte 0 in bits 127:120 |
| rk_idx | output | 4 | Index of the round key needed this cycle |
| round_key | input | 128 | Round key selected by `rk_idx`, same cycle |
| dout | output | 128 | Result block, meaningful while `dout_valid` is high |
| dout_valid | output | 1 | One-cycle strobe marking a result |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a block's valid cycle and the start of the next block. The bench streams with `en` held high and changes `din` during the valid cycle, and it checks that the next result arrives exactly 44 cycles later with the value computed from the new input. The second pair is an abort and a pause: `clr` is raised both while `en` is high and while `en` is low. A behavioural model expects the step count to return to zero and no stray strobe in either case, and it compares the strobe, the key index and the result on every clock.

// File: rtl/aes128_iter_core.sv
module aes128_iter_core #(
  parameter int MODE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         enc_sel,
  input  logic         key_ready,
  input  logic [127:0] din,
  output logic [3:0]   rk_idx,
  input  logic [127:0] round_key,
  output logic [127:0] dout,
  output logic         dout_valid
);
  localparam int NR    = 10;
  localparam int STEPS = 4 * (NR + 1);
  localparam int SW    = $clog2(STEPS);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, p;
    r = '0;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ p;
      p = xt(p);
    end
    return r;
  endfunction

  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] p, r;
    p = x;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] b, input int k);
    return (b << k) | (b >> (8 - k));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] y;
    y = gf_inv(x);
    return y ^ rl(y, 1) ^ rl(y, 2) ^ rl(y, 3) ^ rl(y, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] isbox(input logic [7:0] x);
    return gf_inv(rl(x, 1) ^ rl(x, 3) ^ rl(x, 6) ^ 8'h05);
  endfunction

  function automatic logic [7:0] cmul(input logic [7:0] a, input logic [3:0] m);
    logic [7:0] a2, a4, a8;
    a2 = xt(a);
    a4 = xt(a2);
    a8 = xt(a4);
    return (m[0] ? a : 8'h00) ^ (m[1] ? a2 : 8'h00) ^ (m[2] ? a4 : 8'h00) ^ (m[3] ? a8 : 8'h00);
  endfunction

  function automatic logic [31:0] mixc(input logic [31:0] c, input logic inv);
    logic [3:0]  co [4];
    logic [7:0]  b;
    logic [31:0] r;
    co[0] = inv ? 4'he : 4'h2;
    co[1] = inv ? 4'hb : 4'h3;
    co[2] = inv ? 4'hd : 4'h1;
    co[3] = inv ? 4'h9 : 4'h1;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      b = '0;
      for (int k = 0; k < 4; k++)
        b = b ^ cmul(c[31-8*k -: 8], co[(k - i) & 3]);
      r[31-8*i -: 8] = b;
    end
    return r;
  endfunction

  logic [SW-1:0]  step;
  logic           enc_q;
  logic [127:0]   st;
  logic [95:0]    nx;
  logic           cur_enc;
  logic [SW-3:0]  rnd;
  logic [1:0]     col;
  logic [127:0]   src;
  logic [7:0]     src_b [16];
  logic [7:0]     se [4];
  logic [7:0]     sd [4];
  logic [31:0]    kc, g0, out_e, out_d, col_out;
  logic           first, last_rnd, init_rnd;

  assign rnd      = step[SW-1:2];
  assign col      = step[1:0];
  assign first    = (step == '0);
  assign init_rnd = (rnd == '0);
  assign last_rnd = (rnd == (SW-2)'(NR));
  assign src      = first ? din : st;
  assign kc       = round_key[127 - 32*col -: 32];
  assign g0       = src[127 - 32*col -: 32];

  generate
    if (MODE == 1) begin : g_enc_only
      assign cur_enc = 1'b1;
    end else if (MODE == 2) begin : g_dec_only
      assign cur_enc = 1'b0;
    end else begin : g_both
      assign cur_enc = first ? enc_sel : enc_q;
    end
  endgenerate

  assign rk_idx = cur_enc ? 4'(rnd) : 4'(NR) - 4'(rnd);

  for (genvar i = 0; i < 16; i++) begin : g_bytes
    assign src_b[i] = src[127 - 8*i -: 8];
  end

  for (genvar j = 0; j < 4; j++) begin : g_lane
    if (MODE != 2) begin : g_fwd
      assign se[j] = sbox(src_b[{col + 2'(j), 2'(j)}]);
    end else begin : g_nofwd
      assign se[j] = '0;
    end
    if (MODE != 1) begin : g_inv
      assign sd[j] = isbox(src_b[{col - 2'(j), 2'(j)}]);
    end else begin : g_noinv
      assign sd[j] = '0;
    end
  end

  logic [31:0] s_e, t_d;
  assign s_e = {se[0], se[1], se[2], se[3]};
  assign t_d = {sd[0], sd[1], sd[2], sd[3]} ^ kc;

  generate
    if (MODE != 2) begin : g_out_e
      assign out_e = init_rnd ? (g0 ^ kc) : ((last_rnd ? s_e : mixc(s_e, 1'b0)) ^ kc);
    end else begin : g_no_out_e
      assign out_e = '0;
    end
    if (MODE != 1) begin : g_out_d
      assign out_d = init_rnd ? (g0 ^ kc) : (last_rnd ? t_d : mixc(t_d, 1'b1));
    end else begin : g_no_out_d
      assign out_d = '0;
    end
  endgenerate

  assign col_out = cur_enc ? out_e : out_d;
  assign dout    = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= '0;
      enc_q      <= (MODE != 2);
      st         <= '0;
      nx         <= '0;
      dout_valid <= 1'b0;
    end else if (clr) begin
      step       <= '0;
      dout_valid <= 1'b0;
    end else if (en && key_ready) begin
      dout_valid <= (step == LAST);
      step       <= (step == LAST) ? '0 : step + 1'b1;
      if (first) enc_q <= cur_enc;
      if (col == 2'd3) begin
        st <= {nx, col_out};
      end else begin
        nx[95 - 32*col -: 32] <= col_out;
        if (first) st <= din;
      end
    end else begin
      dout_valid <= 1'b0;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) dout_valid |=> !dout_valid); // R3
  AST_VALID_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) dout_valid |-> (step == '0)); // R4
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!en && !clr) |=> ($stable(step) && !dout_valid)); // R5
  AST_CLEAR_ABORT: assert property (@(posedge clk) disable iff (!rst_n) clr |=> ((step == '0) && !dout_valid)); // R6
  AST_KEY_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (!key_ready && !clr) |=> $stable(step)); // R7
  AST_RK_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rk_idx <= 4'(NR)); // R9
  AST_RK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (en && key_ready && !clr && col == 2'd3 && !last_rnd) |=>
      (rk_idx == (enc_q ? $past(rk_idx) + 4'd1 : $past(rk_idx) - 4'd1))); // R9
endmodule

// File: tb/aes128_iter_core_bench.sv
module aes128_iter_core_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, en, clr, enc_sel, key_ready;
  logic [127:0] din, round_key, dout;
  logic [3:0]   rk_idx;
  logic         dout_valid;

  logic [7:0]   sb_t  [256];
  logic [7:0]   isb_t [256];
  logic [127:0] rks   [16];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  assign round_key = rks[rk_idx];

  aes128_iter_core #(.MODE(3)) u_aes128_iter_core (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .enc_sel(enc_sel),
    .key_ready(key_ready), .din(din), .rk_idx(rk_idx), .round_key(round_key),
    .dout(dout), .dout_valid(dout_valid)
  );

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, p;
    r = '0;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ p;
      p = p[7] ? ((p << 1) ^ 8'h1b) : (p << 1);
    end
    return r;
  endfunction

  task automatic build_tables();
    logic [7:0] inv, y, c;
    c = 8'h63;
    for (int x = 0; x < 256; x++) begin
      inv = '0;
      for (int v = 1; v < 256; v++)
        if (bmul(8'(x), 8'(v)) == 8'h01) inv = 8'(v);
      for (int i = 0; i < 8; i++)
        y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
      sb_t[x] = y;
    end
    for (int x = 0; x < 256; x++) isb_t[sb_t[x]] = 8'(x);
  endtask

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127 - 32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb_t[t[23:16]], sb_t[t[15:8]], sb_t[t[7:0]], sb_t[t[31:24]]} ^ {rc, 24'h0};
        rc = rc[7] ? ((rc << 1) ^ 8'h1b) : (rc << 1);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 16; r++)
      rks[r] = (r < 11) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : '0;
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] blk);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = blk[127-8*i -: 8] ^ rks[0][127-8*i -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int c = 0; c < 4; c++)
        for (int j = 0; j < 4; j++) t[4*c+j] = sb_t[s[4*((c+j)%4)+j]];
      for (int c = 0; c < 4; c++) begin
        if (r < 10) begin
          s[4*c]   = bmul(t[4*c],8'h02) ^ bmul(t[4*c+1],8'h03) ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+1] = t[4*c] ^ bmul(t[4*c+1],8'h02) ^ bmul(t[4*c+2],8'h03) ^ t[4*c+3];
          s[4*c+2] = t[4*c] ^ t[4*c+1] ^ bmul(t[4*c+2],8'h02) ^ bmul(t[4*c+3],8'h03);
          s[4*c+3] = bmul(t[4*c],8'h03) ^ t[4*c+1] ^ t[4*c+2] ^ bmul(t[4*c+3],8'h02);
        end else begin
          for (int j = 0; j < 4; j++) s[4*c+j] = t[4*c+j];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ rks[r][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  function automatic logic [127:0] ref_dec(input logic [127:0] blk);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = blk[127-8*i -: 8] ^ rks[10][127-8*i -: 8];
    for (int r = 9; r >= 0; r--) begin
      for (int c = 0; c < 4; c++)
        for (int j = 0; j < 4; j++) t[4*c+j] = isb_t[s[4*((c+4-j)%4)+j]] ^ rks[r][127-8*(4*c+j) -: 8];
      for (int c = 0; c < 4; c++) begin
        if (r > 0) begin
          s[4*c]   = bmul(t[4*c],8'h0e) ^ bmul(t[4*c+1],8'h0b) ^ bmul(t[4*c+2],8'h0d) ^ bmul(t[4*c+3],8'h09);
          s[4*c+1] = bmul(t[4*c],8'h09) ^ bmul(t[4*c+1],8'h0e) ^ bmul(t[4*c+2],8'h0b) ^ bmul(t[4*c+3],8'h0d);
          s[4*c+2] = bmul(t[4*c],8'h0d) ^ bmul(t[4*c+1],8'h09) ^ bmul(t[4*c+2],8'h0e) ^ bmul(t[4*c+3],8'h0b);
          s[4*c+3] = bmul(t[4*c],8'h0b) ^ bmul(t[4*c+1],8'h0d) ^ bmul(t[4*c+2],8'h09) ^ bmul(t[4*c+3],8'h0e);
        end else begin
          for (int j = 0; j < 4; j++) s[4*c+j] = t[4*c+j];
        end
      end
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle reference model
  int           mstep = 0;
  bit           mvalid = 0;
  bit           menc = 1;
  logic [127:0] mblk = '0;
  logic [127:0] expq = '0;
  logic [3:0]   exp_rk;

  always @(posedge clk) begin
    #1;
    if (!rst_n || clr) begin
      mstep  = 0;
      mvalid = 0;
    end else if (en && key_ready) begin
      if (mstep == 0) begin
        mblk = din;
        menc = enc_sel;
      end
      mvalid = (mstep == 43);
      if (mvalid) expq = menc ? ref_enc(mblk) : ref_dec(mblk);
      mstep = (mstep + 1) % 44;
    end else begin
      mvalid = 0;
    end
    #1;
    if (!done) begin
      chk(dout_valid == mvalid, "R3 valid strobe", 128'(dout_valid), 128'(mvalid));
      if (mvalid) chk(dout == expq, menc ? "R1 encrypt result" : "R2 decrypt result", dout, expq);
      exp_rk = ((mstep == 0) ? enc_sel : menc) ? 4'(mstep / 4) : 4'(10 - mstep / 4);
      chk(rk_idx == exp_rk, "R9 round key index", 128'(rk_idx), 128'(exp_rk));
    end
  end

  task automatic wait_valid(output int n);
    n = 0;
    do begin
      @(posedge clk);
      #2;
      n++;
    end while (!dout_valid && n < 200);
  endtask

  task automatic restart();
    @(negedge clk);
    en  = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic load_key(input logic [127:0] k);
    @(negedge clk);
    key_ready = 1'b0;
    expand(k);
    @(negedge clk);
    key_ready = 1'b1;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;

  initial begin
    int n;
    logic [127:0] a, b, x;
    rst_n = 1'b0; en = 1'b0; clr = 1'b0; enc_sel = 1'b1; key_ready = 1'b0; din = '0;
    build_tables();
    expand(K1);
    repeat (3) @(posedge clk);
    #2;
    chk(dout_valid == 1'b0, "R10 reset strobe", 128'(dout_valid), 128'(0));
    chk(rk_idx == 4'd0, "R10 reset key index", 128'(rk_idx), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    key_ready = 1'b1;

    // R1 and R3: known vector, latency
    restart();
    @(negedge clk);
    din = P1; enc_sel = 1'b1; en = 1'b1;
    wait_valid(n);
    chk(dout == C1, "R1 known encryption", dout, C1);
    chk(n == 44, "R3 latency", 128'(n), 128'(44));

    // R4: streaming, next input taken at the edge closing the valid cycle
    a = rnd128(); b = rnd128();
    @(negedge clk);
    din = a;
    wait_valid(n);
    chk(n == 44, "R4 back-to-back spacing", 128'(n), 128'(44));
    chk(dout == ref_enc(a), "R4 streamed result", dout, ref_enc(a));
    @(negedge clk);
    din = b;
    wait_valid(n);
    chk(n == 44, "R4 back-to-back spacing", 128'(n), 128'(44));

    // R2: known vector decryption
    restart();
    @(negedge clk);
    din = C1; enc_sel = 1'b0; en = 1'b1;
    wait_valid(n);
    chk(dout == P1, "R2 known decryption", dout, P1);

    // R5: pause for 7 edges
    restart();
    x = rnd128();
    @(negedge clk);
    din = x; enc_sel = 1'b1; en = 1'b1;
    n = 0;
    repeat (10) begin @(posedge clk); n++; end
    @(negedge clk);
    en = 1'b0;
    repeat (7) begin @(posedge clk); n++; end
    @(negedge clk);
    en = 1'b1;
    begin
      int m;
      wait_valid(m);
      n += m;
    end
    chk(n == 51, "R5 paused latency", 128'(n), 128'(51));
    chk(dout == ref_enc(x), "R5 paused result", dout, ref_enc(x));

    // R6: abort mid-block while enabled, fresh block right after
    restart();
    a = rnd128(); b = rnd128();
    @(negedge clk);
    din = a; enc_sel = 1'b1; en = 1'b1;
    repeat (20) @(negedge clk);
    clr = 1'b1; din = b;
    @(negedge clk);
    clr = 1'b0;
    wait_valid(n);
    chk(n == 44, "R6 fresh block latency", 128'(n), 128'(44));
    chk(dout == ref_enc(b), "R6 fresh block result", dout, ref_enc(b));

    // R7: no progress without key_ready, then second known vector
    restart();
    @(negedge clk);
    key_ready = 1'b0; en = 1'b1; enc_sel = 1'b1; din = P2;
    repeat (12) @(posedge clk);
    #2;
    chk(dout_valid == 1'b0 && rk_idx == 4'd0, "R7 held without key", 128'(rk_idx), 128'(0));
    @(negedge clk);
    en = 1'b0;
    load_key(K2);
    @(negedge clk);
    en = 1'b1;
    wait_valid(n);
    chk(dout == C2, "R7 encryption after key ready", dout, C2);
    chk(n == 44, "R7 latency after key ready", 128'(n), 128'(44));

    // R8: input changes after the first edge are ignored
    restart();
    x = rnd128();
    @(negedge clk);
    din = x; enc_sel = 1'b1; en = 1'b1;
    repeat (20) begin @(negedge clk); din = rnd128(); end
    wait_valid(n);
    chk(dout == ref_enc(x), "R8 input captured once", dout, ref_enc(x));

    // R11: direction changes within a block are ignored
    restart();
    x = rnd128();
    @(negedge clk);
    din = x; enc_sel = 1'b0; en = 1'b1;
    repeat (5) @(negedge clk);
    enc_sel = 1'b1;
    wait_valid(n);
    chk(dout == ref_dec(x), "R11 direction held", dout, ref_dec(x));

    // mixed stream, round-trip of an encryption
    restart();
    a = rnd128();
    @(negedge clk);
    din = a; enc_sel = 1'b1; en = 1'b1;
    wait_valid(n);
    b = dout;
    @(negedge clk);
    din = b; enc_sel = 1'b0;
    wait_valid(n);
    chk(dout == a, "R2 round trip", dout, a);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      din = rnd128(); enc_sel = k[0];
      wait_valid(n);
    end

    restart();
    done = 1;
    finish_run();
  end
endmodule